// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block steps an external ADC through five voltage channels and keeps the latest result of each channel in a small bank of value registers. It raises a request with a channel number and waits for the converter to return a sample. By default it sums sixteen accepted samples in an accumulator four bits wider than a sample, divides the sum by sixteen and stores the result. Until that sixteenth sample arrives, the value register keeps its old content.

Two run-time controls change the pattern. `cfg_avg_off` stores every accepted sample directly, so results arrive sixteen times as often. `cfg_single` drops the round-robin and converts only the channel picked by the 3-bit `cfg_chan_sel` field, over and over. Channel codes are 0 = 2.5 V, 1 = processor core supply, 2 = VCC, 3 = 5 V and 4 = 12 V. A change to either control, or to the selected channel while single-channel mode runs, ends the current group at once and throws away its partial sum. A fresh group then starts with the new settings. A registered read port returns any value register.

Top module: `adcseq_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `adc_req` is 0 and every value register reads back as 0.
- R2: Once raised, `adc_req` stays high with `adc_chan` constant until a sample is accepted, which happens in a cycle with both `adc_req` and `adc_valid` high. A high `adc_valid` has no effect while `adc_req` is low.
- R3: With averaging on, the value register of the group's channel is written only on the 16th accepted sample. It receives the floor of the sum of the 16 samples divided by 16.
- R4: With `cfg_avg_off` = 1, every accepted sample is written unchanged to the value register of its channel.
- R5: With `cfg_single` = 0, groups visit channels 0, 1, 2, 3, 4 in that order and then wrap to 0, one group per channel.
- R6: With `cfg_single` = 1, every group converts the channel coded by `cfg_chan_sel` (codes 0 to 4 as above). On a return to round-robin, the sequence resumes at the channel after the last round-robin channel that was stored.
- R7: `cfg_chan_sel` codes 5, 6 and 7 select channel 0.
- R8: A change in `cfg_avg_off` or `cfg_single` during a group, or in the decoded `cfg_chan_sel` channel while single-channel mode runs, ends the group without a write and discards its partial sum. The next group uses the new settings.
- R9: `rd_data` shows, one cycle after `rd_addr`, the value register at that address for addresses 0 to 4 and 0 for addresses 5 to 7. A read in the same cycle as a write to that register returns the old value.
- R10: After a group ends, whether it completed or was aborted, `adc_req` is low for exactly one cycle before the next group's request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_avg_off | input | 1 | 1 = store single conversions, 0 = store 16-sample average |
| cfg_single | input | 1 | 1 = convert only the selected channel |
| cfg_chan_sel | input | 3 | Channel code for single-channel mode |
| adc_req | output | 1 | Conversion request to the ADC |
| adc_chan | output | 3 | Channel being requested |
| adc_valid | input | 1 | ADC sample is present on `adc_data` |
| adc_data | input | 10 | ADC sample |
| rd_addr | input | 3 | Value register read address |
| rd_data | output | 10 | Registered read data |

## Verification
The assertions assume that `adc_data` is valid in every cycle in which `adc_valid` is high, and that the control inputs are synchronous to `clk`. They also assume a handshake in which the converter may raise `adc_valid` at any time, even with no request pending. The bench drives every input one half period away from the rising edge. It toggles `adc_valid` pseudo-randomly whether or not a request is pending, and it changes the controls only in cycles it chooses. Because the sample word can never exceed 10 bits, the accumulator bound assertion holds for every stimulus.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic {PH_START = 1'b0, PH_RUN = 1'b1} seq_phase_t;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NCH      = 5,
  parameter int SELW     = 3,
  parameter int AVG_LOG2 = 4,
  localparam int CHW     = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_avg_off,
  input  logic            cfg_single,
  input  logic [SELW-1:0] cfg_sel,
  input  logic            adc_valid,
  output logic            adc_req,
  output logic [CHW-1:0]  adc_chan,
  output logic            take,
  output logic            done,
  output logic            clr,
  output logic            avg_off_q
);

  seq_phase_t            ph_q;
  logic [CHW-1:0]        ch_q, rr_q, sel_ch, rr_next;
  logic                  single_q, avgoff_q;
  logic [AVG_LOG2-1:0]   cnt_q;
  logic                  cfg_diff, run, last;

  // codes beyond the last channel fold onto channel 0 (R7)
  always_comb sel_ch = (int'(cfg_sel) < NCH) ? CHW'(cfg_sel) : '0;

  always_comb begin
    run      = (ph_q == PH_RUN);
    cfg_diff = (cfg_avg_off != avgoff_q) || (cfg_single != single_q) ||
               (single_q && (sel_ch != ch_q));
    take     = run && !cfg_diff && adc_valid;
    last     = avgoff_q || (cnt_q == '1);
    done     = take && last;
    clr      = (ph_q == PH_START);
    rr_next  = (ch_q == CHW'(NCH - 1)) ? '0 : ch_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_START;
      ch_q     <= '0;
      rr_q     <= '0;
      single_q <= 1'b0;
      avgoff_q <= 1'b0;
      cnt_q    <= '0;
    end else if (ph_q == PH_START) begin
      single_q <= cfg_single;
      avgoff_q <= cfg_avg_off;
      ch_q     <= cfg_single ? sel_ch : rr_q;
      cnt_q    <= '0;
      ph_q     <= PH_RUN;
    end else if (cfg_diff) begin
      ph_q <= PH_START;           // abort, partial sum dropped (R8)
    end else if (take) begin
      if (last) begin
        ph_q <= PH_START;
        if (!single_q) rr_q <= rr_next;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign adc_req   = run;
  assign adc_chan  = ch_q;
  assign avg_off_q = avgoff_q;

  assert_chan_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (adc_req && $past(adc_req)) |-> $stable(adc_chan));

  assert_chan_range_R5: assert property (@(posedge clk) disable iff (rst)
    int'(adc_chan) < NCH);

  assert_gap_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !adc_req);

  assert_no_take_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !adc_req |-> !take);

endmodule

// File: rtl/adcseq_accum.sv
module adcseq_accum #(
  parameter int DW       = 10,
  parameter int AVG_LOG2 = 4,
  localparam int ACCW    = DW + AVG_LOG2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add,
  input  logic          avg_off,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] result
);

  localparam logic [ACCW-1:0] ACC_MAX =
    ACCW'(((1 << AVG_LOG2) - 1) * ((1 << DW) - 1));

  logic [ACCW-1:0] acc_q, sum;

  always_comb begin
    sum    = acc_q + ACCW'(din);
    result = avg_off ? din : sum[ACCW-1:AVG_LOG2];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (add)   acc_q <= sum;
  end

  // before the last sample the sum holds at most 15 full-scale samples (R3)
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    acc_q <= ACC_MAX);

endmodule

// File: rtl/adcseq_bank.sv
module adcseq_bank #(
  parameter int DW   = 10,
  parameter int NCH  = 5,
  localparam int CHW = $clog2(NCH),
  localparam int NSLOT = 1 << CHW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [CHW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data
);

  logic [DW-1:0] mem [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= (int'(rd_addr) < NCH) ? mem[rd_addr] : '0;
      if (wr_en) mem[wr_addr] <= wr_data;
    end
  end

  assert_write_addr_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < NCH));

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int DW       = 10,
  parameter int NCH      = 5,
  parameter int SELW     = 3,
  parameter int AVG_LOG2 = 4,
  localparam int CHW     = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_avg_off,
  input  logic            cfg_single,
  input  logic [SELW-1:0] cfg_chan_sel,
  output logic            adc_req,
  output logic [CHW-1:0]  adc_chan,
  input  logic            adc_valid,
  input  logic [DW-1:0]   adc_data,
  input  logic [CHW-1:0]  rd_addr,
  output logic [DW-1:0]   rd_data
);

  logic          take, done, clr, avg_off_q;
  logic [DW-1:0] result;

  adcseq_ctrl #(.NCH(NCH), .SELW(SELW), .AVG_LOG2(AVG_LOG2)) u_ctrl (
    .clk(clk), .rst(rst),
    .cfg_avg_off(cfg_avg_off), .cfg_single(cfg_single), .cfg_sel(cfg_chan_sel),
    .adc_valid(adc_valid), .adc_req(adc_req), .adc_chan(adc_chan),
    .take(take), .done(done), .clr(clr), .avg_off_q(avg_off_q)
  );

  adcseq_accum #(.DW(DW), .AVG_LOG2(AVG_LOG2)) u_accum (
    .clk(clk), .rst(rst), .clr(clr), .add(take && !done),
    .avg_off(avg_off_q), .din(adc_data), .result(result)
  );

  adcseq_bank #(.DW(DW), .NCH(NCH)) u_bank (
    .clk(clk), .rst(rst), .wr_en(done), .wr_addr(adc_chan),
    .wr_data(result), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assert_avgoff_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (done && avg_off_q) |-> (result == adc_data));

endmodule

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_avg_off, cfg_single;
  logic [2:0] cfg_chan_sel, adc_chan, rd_addr;
  logic       adc_req, adc_valid;
  logic [9:0] adc_data, rd_data;

  always #10 clk = ~clk;  // 50 MHz

  adcseq_top u_dut (
    .clk(clk), .rst(rst), .cfg_avg_off(cfg_avg_off), .cfg_single(cfg_single),
    .cfg_chan_sel(cfg_chan_sel), .adc_req(adc_req), .adc_chan(adc_chan),
    .adc_valid(adc_valid), .adc_data(adc_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // stimulus controls
  bit r_q = 1, ao_q = 0, sg_q = 0, en = 0, fixed = 0, rd_fix = 0, finished = 0;
  int sel_q = 0, base = 0, k = 0, rd_sel = 0, rd_cyc = 0;
  bit [31:0] lf = 32'h1ace_b00c;
  int checks = 0, fails = 0;

  // behavioural reference
  int m_ph = 0, m_ch = 0, m_rr = 0, m_cnt = 0, m_acc = 0, m_rd = 0;
  bit m_sg = 0, m_ao = 0, m_live = 0;
  int m_val[5];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    bit v;
    int d, sel;
    @(negedge clk);
    if (m_live) begin
      chk(adc_req == (m_ph == 1), "R10 R2 adc_req", adc_req, m_ph == 1);
      if (m_ph == 1) chk(int'(adc_chan) == m_ch, "R5 R6 R2 adc_chan", adc_chan, m_ch);
      chk(int'(rd_data) == m_rd, "R9 R3 R4 rd_data", rd_data, m_rd);
    end
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    v = en && lf[3];
    d = fixed ? base + k : int'(lf[17:8]);
    rst = r_q; cfg_avg_off = ao_q; cfg_single = sg_q; cfg_chan_sel = 3'(sel_q);
    adc_valid = lf[3];   // valid also appears while idle (R2)
    if (!v) adc_valid = 1'b0;
    adc_data = 10'(d);
    if (rd_fix) rd_addr = 3'(rd_sel);
    else begin rd_addr = 3'(rd_cyc); rd_cyc = (rd_cyc + 1) % 8; end
    if (!en) adc_valid = lf[5] & lf[9] & ~m_ph[0]; // idle-only valid noise
    v = adc_valid;
    if (r_q) begin
      m_ph = 0; m_ch = 0; m_rr = 0; m_cnt = 0; m_acc = 0; m_rd = 0;
      m_sg = 0; m_ao = 0; m_live = 1;
      foreach (m_val[i]) m_val[i] = 0;
    end else begin
      m_rd = (int'(rd_addr) < 5) ? m_val[rd_addr] : 0;
      sel = (sel_q < 5) ? sel_q : 0;
      if (m_ph == 0) begin
        m_sg = sg_q; m_ao = ao_q; m_ch = sg_q ? sel : m_rr;
        m_cnt = 0; m_acc = 0; m_ph = 1;
      end else if (ao_q != m_ao || sg_q != m_sg || (m_sg && sel != m_ch)) begin
        m_ph = 0;
      end else if (v) begin
        k++;
        m_acc += d; m_cnt++;
        if (m_ao || m_cnt == 16) begin
          m_val[m_ch] = m_ao ? d : m_acc / 16;
          m_ph = 0;
          if (!m_sg) m_rr = (m_ch + 1) % 5;
        end
      end
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check_val(int a, int exp, string tag);
    en = 0; rd_fix = 1; rd_sel = a;
    tick();
    #12;
    chk(int'(rd_data) == exp, tag, rd_data, exp);
    rd_fix = 0;
  endtask

  task automatic prep(bit ao, bit sg, int sel, int b);
    en = 0; ao_q = ao; sg_q = sg; sel_q = sel;
    ticks(3);
    k = 0; base = b; fixed = 1; en = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    r_q = 1;
    ticks(3);
    r_q = 0;
    #12;
    chk(adc_req == 1'b0, "R1 req after reset", adc_req, 0);
    for (int a = 0; a < 5; a++) check_val(a, 0, "R1 value after reset");
    // round-robin, averaging, random data
    fixed = 0; en = 1; ticks(2000);
    // round-robin, single conversions
    ao_q = 1; ticks(400);
    // single-channel sweep including folded codes
    for (int s = 0; s < 8; s++) begin sg_q = 1; sel_q = s; ticks(120); end
    ao_q = 0; ticks(600);
    // R3: average of 1000..1015 is 1007
    prep(0, 1, 1, 1000);
    while (k < 16) tick();
    en = 0; ticks(2);
    check_val(1, 1007, "R3 average stored");
    // R4: single conversion stored unchanged
    prep(1, 1, 3, 341);
    while (k < 1) tick();
    en = 0; ticks(2);
    check_val(3, 341, "R4 direct store");
    // R7: code 6 targets channel 0
    prep(1, 1, 6, 77);
    while (k < 1) tick();
    en = 0; ticks(2);
    check_val(0, 77, "R7 folded code");
    // R8: partial averaging group dropped on mode change
    prep(0, 1, 2, 500);
    while (k < 5) tick();
    en = 0; ao_q = 1; ticks(3);
    k = 0; base = 300; en = 1;
    while (k < 1) tick();
    en = 0; ticks(2);
    check_val(2, 300, "R8 abort then new mode");
    check_val(6, 0, "R9 unused address");
    // back to round-robin: resume position (R6)
    fixed = 0; sg_q = 0; ao_q = 0; en = 1; ticks(1500);
    finished = 1;
    summary();
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
    end
  end
endmodule